// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block sits between a host programmed-I/O port and the register logic of a dual-channel IDE controller. Each access carries an address, a size code, a direction and a write byte. The block checks the address against five windows, each with its own run-time base and a fixed size: a command window and a control window for each channel, and one bus-master window shared by both channels. From the matching window it works out the window kind, the channel, the offset inside the window and which of the four attached drives the access is for.

Each channel has a one-bit shadow of its drive-select bit. The shadow is taken from writes to the drive-select register, so the drive index is known without asking the drive. Two enables gate the accesses: an I/O enable gates all traffic, and a bus-master enable gates writes to the bus-master window. An address that hits no window, or a size that is not allowed for the window it hits, gives a one-cycle error pulse and has no other effect.

Top module: `ide_pio_decoder`

## Requirements
- R1: Windows are tested in a fixed priority order: primary command, primary control, secondary command, secondary control, bus-master. The first window that holds the address wins. A window holds addresses from base to base+size-1. `rsp_offset` is the address minus the winning base. `rsp_kind` is 0 for a command window, 1 for a control window and 2 for the bus-master window.
- R2: In the bus-master window, an offset below `BM_CH1_OFS` (default 8) gives `rsp_chan`=0 (primary). Any other offset gives `rsp_chan`=1 (secondary).
- R3: An accepted write to command-window offset `SEL_OFS` (default 6) loads bit `DEV_BIT` (default 4) of `req_wdata` into that channel's shadow drive-select bit. No other access changes a shadow bit.
- R4: `rsp_drive` = 2*`rsp_chan` + the channel's shadow bit. For a drive-select write, the response already uses the newly written bit.
- R5: While `io_en` is 0, an access that hits a window with a legal size gives no `rsp_valid` and no `rsp_err`, and it leaves the shadows unchanged.
- R6: While `bm_en` is 0, writes to the bus-master window are dropped in the same way. Reads of that window are still forwarded.
- R7: `req_size` codes 0, 1 and 2 mean 1, 2 and 4 bytes. Code 3 is an error. A 4-byte access to a command or control window is also an error.
- R8: An address that hits no window is an error, whatever the enables are.
- R9: An error gives `rsp_err` high for exactly one cycle and no `rsp_valid`, and it leaves the shadows unchanged.
- R10: The response to a request sampled on one clock edge appears on the next edge. A cycle with no request gives neither `rsp_valid` nor `rsp_err`.
- R11: Reset clears both shadow bits and deasserts `rsp_valid` and `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master write enable |
| base_pcmd | input | ADDR_W | Primary command window base |
| base_pctl | input | ADDR_W | Primary control window base |
| base_scmd | input | ADDR_W | Secondary command window base |
| base_sctl | input | ADDR_W | Secondary control window base |
| base_bm | input | ADDR_W | Bus-master window base |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_size | input | 2 | Size code (0=1B, 1=2B, 2=4B, 3=illegal) |
| req_wdata | input | DATA_W | Low byte of write data |
| rsp_valid | output | 1 | Decoded access forwarded |
| rsp_err | output | 1 | One-cycle error pulse |
| rsp_write | output | 1 | Direction of forwarded access |
| rsp_size | output | 2 | Size code of forwarded access |
| rsp_kind | output | 2 | Window kind (0 cmd, 1 ctrl, 2 bus-master) |
| rsp_chan | output | 1 | Channel (0 primary, 1 secondary) |
| rsp_offset | output | OFS_W | Offset inside the window |
| rsp_drive | output | 2 | Target drive index 0..3 |

## Verification
Every result, including `rsp_err`, is registered once, so it is due on the first rising edge after the request. A drive-select write changes the shadow on that same edge, so its own response and every later response show the new bit. The bench raises the request at a falling edge, drops it at the next falling edge and samples there, half a period after the register updates. For an error vector it takes one more idle sample to show that the pulse is gone. Effects on the shadows that cannot be seen directly are read back through `rsp_drive` on a later access.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_CTL  = 2'd1,
    KIND_BM   = 2'd2,
    KIND_NONE = 2'd3
  } win_kind_e;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_BAD = 2'd3
  } acc_size_e;

  localparam int NUM_WIN = 5;
  localparam int NUM_CH  = 2;

  // window index -> kind / fixed channel (bus-master channel comes from offset)
  function automatic win_kind_e win_kind(input int idx);
    case (idx)
      0, 2:    return KIND_CMD;
      1, 3:    return KIND_CTL;
      4:       return KIND_BM;
      default: return KIND_NONE;
    endcase
  endfunction

  function automatic logic win_chan(input int idx);
    return (idx == 2 || idx == 3);
  endfunction
endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 4,
  parameter int SIZE   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit,
  output logic [OFS_W-1:0]  ofs
);
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = addr - base;
    hit  = (addr >= base) && ({1'b0, diff} < (ADDR_W+1)'(SIZE));
    ofs  = diff[OFS_W-1:0];
  end
endmodule

// File: rtl/ide_win_prio.sv
module ide_win_prio #(
  parameter int N     = 5,
  parameter int OFS_W = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hit,
  input  logic [OFS_W-1:0] ofs [N],
  output logic             any_hit,
  output logic [IDX_W-1:0] sel_idx,
  output logic [OFS_W-1:0] sel_ofs
);
  always_comb begin
    any_hit = |hit;
    sel_idx = '0;
    sel_ofs = '0;
    // walk from lowest priority up so the lowest index wins
    for (int i = N-1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_idx = IDX_W'(i);
        sel_ofs = ofs[i];
      end
    end
  end
endmodule

// File: rtl/ide_dev_shadow.sv
module ide_dev_shadow #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_en,
  input  logic           upd_chan,
  input  logic           upd_bit,
  output logic [NCH-1:0] dev_q
);
  logic [NCH-1:0] dev_d;

  always_comb begin
    dev_d = dev_q;
    for (int c = 0; c < NCH; c++) begin
      if (upd_en && (int'(upd_chan) == c)) dev_d[c] = upd_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_q <= '0;
    else if (upd_en) dev_q <= dev_d;
  end
endmodule

// File: rtl/ide_pio_decoder.sv
module ide_pio_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CMD_SIZE   = 8,
  parameter int CTL_SIZE   = 4,
  parameter int BM_SIZE    = 16,
  parameter int BM_CH1_OFS = 8,
  parameter int SEL_OFS    = 6,
  parameter int DEV_BIT    = 4,
  parameter int OFS_W      = $clog2((BM_SIZE > CMD_SIZE ? BM_SIZE : CMD_SIZE) > CTL_SIZE ?
                                    (BM_SIZE > CMD_SIZE ? BM_SIZE : CMD_SIZE) : CTL_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_en,
  input  logic              bm_en,
  input  logic [ADDR_W-1:0] base_pcmd,
  input  logic [ADDR_W-1:0] base_pctl,
  input  logic [ADDR_W-1:0] base_scmd,
  input  logic [ADDR_W-1:0] base_sctl,
  input  logic [ADDR_W-1:0] base_bm,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_write,
  output logic [1:0]        rsp_size,
  output logic [1:0]        rsp_kind,
  output logic              rsp_chan,
  output logic [OFS_W-1:0]  rsp_offset,
  output logic [1:0]        rsp_drive
);
  localparam int IDX_W = $clog2(NUM_WIN);

  function automatic int win_size(input int idx);
    case (idx)
      0, 2:    return CMD_SIZE;
      1, 3:    return CTL_SIZE;
      default: return BM_SIZE;
    endcase
  endfunction

  logic [ADDR_W-1:0] base_arr [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic [OFS_W-1:0]   ofs_arr [NUM_WIN];

  assign base_arr[0] = base_pcmd;
  assign base_arr[1] = base_pctl;
  assign base_arr[2] = base_scmd;
  assign base_arr[3] = base_sctl;
  assign base_arr[4] = base_bm;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ide_win_match #(
      .ADDR_W(ADDR_W),
      .OFS_W (OFS_W),
      .SIZE  (win_size(w))
    ) u_match (
      .addr(req_addr),
      .base(base_arr[w]),
      .hit (hit[w]),
      .ofs (ofs_arr[w])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [OFS_W-1:0] sel_ofs;

  ide_win_prio #(
    .N    (NUM_WIN),
    .OFS_W(OFS_W),
    .IDX_W(IDX_W)
  ) u_prio (
    .hit    (hit),
    .ofs    (ofs_arr),
    .any_hit(any_hit),
    .sel_idx(sel_idx),
    .sel_ofs(sel_ofs)
  );

  // decode of the selected window
  win_kind_e  kind;
  logic       chan;
  logic       size_bad;
  logic       err_now;
  logic       accept;
  logic       sel_wr;
  logic       dev_bit;
  logic [NUM_CH-1:0] dev_q;

  always_comb begin
    kind = win_kind(int'(sel_idx));
    if (kind == KIND_BM) chan = (int'(sel_ofs) >= BM_CH1_OFS);
    else                 chan = win_chan(int'(sel_idx));
    size_bad = (req_size == SZ_BAD) || ((req_size == SZ_B4) && (kind != KIND_BM));
    err_now  = req_valid && (!any_hit || size_bad);
    accept   = req_valid && any_hit && !size_bad && io_en &&
               !(req_write && (kind == KIND_BM) && !bm_en);
    sel_wr   = accept && req_write && (kind == KIND_CMD) &&
               (int'(sel_ofs) == SEL_OFS);
    dev_bit  = sel_wr ? req_wdata[DEV_BIT] : dev_q[chan];
  end

  ide_dev_shadow #(
    .NCH(NUM_CH)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (sel_wr),
    .upd_chan(chan),
    .upd_bit (req_wdata[DEV_BIT]),
    .dev_q   (dev_q)
  );

  // response registers: strobes every cycle, payload only on accept
  logic             valid_d, err_d;
  logic             write_d;
  logic [1:0]       size_d, kind_d, drive_d;
  logic             chan_d;
  logic [OFS_W-1:0] ofs_d;

  always_comb begin
    valid_d = accept;
    err_d   = err_now;
    write_d = req_write;
    size_d  = req_size;
    kind_d  = kind;
    chan_d  = chan;
    ofs_d   = sel_ofs;
    drive_d = {chan, dev_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_write  <= 1'b0;
      rsp_size   <= '0;
      rsp_kind   <= '0;
      rsp_chan   <= 1'b0;
      rsp_offset <= '0;
      rsp_drive  <= '0;
    end else if (accept) begin
      rsp_write  <= write_d;
      rsp_size   <= size_d;
      rsp_kind   <= kind_d;
      rsp_chan   <= chan_d;
      rsp_offset <= ofs_d;
      rsp_drive  <= drive_d;
    end
  end
endmodule

// File: rtl/ide_pio_decoder_chk.sv
module ide_pio_decoder_chk #(
  parameter int OFS_W      = 4,
  parameter int BM_CH1_OFS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_en,
  input logic             bm_en,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic             rsp_write,
  input logic [1:0]       rsp_size,
  input logic [1:0]       rsp_kind,
  input logic             rsp_chan,
  input logic [OFS_W-1:0] rsp_offset,
  input logic [1:0]       rsp_drive
);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err));

  a_r9_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_valid);

  a_r5_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |=> !rsp_valid);

  a_r6_bm_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_en |=> !(rsp_valid && rsp_write && rsp_kind == 2'd2));

  a_r4_drive_chan: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_drive[1] == rsp_chan));

  a_r2_bm_split: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'd2) |-> (rsp_chan == (int'(rsp_offset) >= BM_CH1_OFS)));

  a_r7_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_size != 2'd3 && !(rsp_size == 2'd2 && rsp_kind != 2'd2)));

  a_r1_known_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3));
endmodule

bind ide_pio_decoder ide_pio_decoder_chk #(
  .OFS_W     (OFS_W),
  .BM_CH1_OFS(BM_CH1_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_en     (io_en),
  .bm_en     (bm_en),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_write (rsp_write),
  .rsp_size  (rsp_size),
  .rsp_kind  (rsp_kind),
  .rsp_chan  (rsp_chan),
  .rsp_offset(rsp_offset),
  .rsp_drive (rsp_drive)
);

// File: tb/tb_ide_pio_decoder.sv
module tb_ide_pio_decoder;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = 4;
  localparam int VW     = 44;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              io_en, bm_en;
  logic [ADDR_W-1:0] base_pcmd, base_pctl, base_scmd, base_sctl, base_bm;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [1:0]        req_size;
  logic [7:0]        req_wdata;
  logic              rsp_valid, rsp_err, rsp_write, rsp_chan;
  logic [1:0]        rsp_size, rsp_kind, rsp_drive;
  logic [OFS_W-1:0]  rsp_offset;

  ide_pio_decoder dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en),
    .base_pcmd(base_pcmd), .base_pctl(base_pctl), .base_scmd(base_scmd),
    .base_sctl(base_sctl), .base_bm(base_bm),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_write(rsp_write),
    .rsp_size(rsp_size), .rsp_kind(rsp_kind), .rsp_chan(rsp_chan),
    .rsp_offset(rsp_offset), .rsp_drive(rsp_drive)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // io bm wr addr size wdata | exp_valid exp_err kind chan ofs drive | req
  function automatic logic [VW-1:0] mk(input bit io, bm, wr, input int addr, sz, wd,
                                       input bit ev, ee, input int ek, ec, eo, edr, rq);
    return {io, bm, wr, 16'(addr), 2'(sz), 8'(wd), ev, ee, 2'(ek), 1'(ec), 4'(eo), 2'(edr), 4'(rq)};
  endfunction

  localparam int NV = 27;
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(1,1,0,'h1F0,0,'h00, 1,0,0,0,0,0, 1),  // R1 primary cmd
    mk(1,1,1,'h1F6,0,'h10, 1,0,0,0,6,1, 3),  // R3 select drive 1
    mk(1,1,0,'h1F7,1,'h00, 1,0,0,0,7,1, 4),  // R4
    mk(1,1,0,'h3F6,0,'h00, 1,0,1,0,2,1, 1),  // R1 primary ctrl
    mk(1,1,1,'h176,0,'hA0, 1,0,0,1,6,2, 3),  // R3 secondary bit 0
    mk(1,1,1,'h176,0,'hF0, 1,0,0,1,6,3, 4),  // R4 new bit shown
    mk(1,1,0,'h375,0,'h00, 1,0,1,1,1,3, 1),  // R1 secondary ctrl
    mk(1,1,0,'hC000,2,'h00, 1,0,2,0,0,1, 2), // R2 bm low half
    mk(1,1,1,'hC008,0,'h00, 1,0,2,1,8,3, 2), // R2 bm split point
    mk(1,1,0,'hC007,0,'h00, 1,0,2,0,7,1, 2), // R2
    mk(1,1,0,'hC00F,2,'h00, 1,0,2,1,15,3, 2),// R2 top of window
    mk(1,1,0,'h1F0,2,'h00, 0,1,0,0,0,0, 7),  // R7 4B to cmd
    mk(1,1,0,'hC000,3,'h00, 0,1,0,0,0,0, 7), // R7 bad code
    mk(1,1,0,'h200,0,'h00, 0,1,0,0,0,0, 8),  // R8 no window
    mk(0,1,0,'h1F0,0,'h00, 0,0,0,0,0,0, 5),  // R5 io off read
    mk(0,1,1,'h1F6,0,'h00, 0,0,0,0,0,0, 5),  // R5 io off select write
    mk(1,1,0,'h1F0,0,'h00, 1,0,0,0,0,1, 5),  // R5 shadow kept
    mk(1,0,1,'hC002,0,'h00, 0,0,0,0,0,0, 6), // R6 bm write dropped
    mk(1,0,0,'hC002,0,'h00, 1,0,2,0,2,1, 6), // R6 bm read passes
    mk(1,1,1,'h1F6,2,'h00, 0,1,0,0,0,0, 9),  // R9 erroneous select
    mk(1,1,0,'h1F1,0,'h00, 1,0,0,0,1,1, 9),  // R9 shadow kept
    mk(1,1,1,'h1F5,0,'h00, 1,0,0,0,5,1, 3),  // R3 other offset
    mk(1,1,1,'h1F6,0,'hEF, 1,0,0,0,6,0, 3),  // R3 bit4 only
    mk(1,1,0,'hC010,0,'h00, 0,1,0,0,0,0, 8), // R8 past bm end
    mk(1,1,0,'h1EF,0,'h00, 0,1,0,0,0,0, 8),  // R8 below cmd
    mk(1,1,0,'h1F8,0,'h00, 0,1,0,0,0,0, 8),  // R8 past cmd end
    mk(0,0,0,'h200,0,'h00, 0,1,0,0,0,0, 8)   // R8 error with io off
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // raise request at a negedge, drop it at the next, outputs are then due
  task automatic issue(input bit wr, input int addr, sz, wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 16'(addr);
    req_size = 2'(sz); req_wdata = 8'(wd);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input int k, c, o, d);
    chk(rsp_valid == 1'b1 && rsp_err == 1'b0, tag, {rsp_valid, rsp_err}, 2);
    chk(rsp_kind == 2'(k) && rsp_chan == 1'(c) && rsp_offset == 4'(o) && rsp_drive == 2'(d),
        tag, {rsp_kind, rsp_chan, rsp_offset, rsp_drive}, {2'(k), 1'(c), 4'(o), 2'(d)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_en = 1'b1; bm_en = 1'b1;
    base_pcmd = 16'h1F0; base_pctl = 16'h3F4; base_scmd = 16'h170;
    base_sctl = 16'h374; base_bm = 16'hC000;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R11 reset outputs", {rsp_valid, rsp_err}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      io_en = v[43]; bm_en = v[42];
      issue(v[41], int'(v[40:25]), int'(v[24:23]), int'(v[22:15]));
      n_chk++;
      if (rsp_valid != v[14] || rsp_err != v[13] ||
          (v[14] && (rsp_kind != v[12:11] || rsp_chan != v[10] ||
                     rsp_offset != v[9:6] || rsp_drive != v[5:4]))) begin
        n_fail++;
        $display("FAIL R%0d vector %0d actual=%0h expected=%0h", v[3:0], i,
                 {rsp_valid, rsp_err, rsp_kind, rsp_chan, rsp_offset, rsp_drive}, v[14:4]);
      end
      if (v[13]) begin
        @(negedge clk);
        chk(rsp_err == 1'b0 && rsp_valid == 1'b0, "R9 error pulse one cycle",
            {rsp_valid, rsp_err}, 0);
      end
    end
    io_en = 1'b1; bm_en = 1'b1;

    // R10 idle cycle after traffic
    @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R10 idle", {rsp_valid, rsp_err}, 0);

    // R1 priority on overlapping windows: primary control moved into cmd range
    base_pctl = 16'h1F6;
    issue(1'b0, 'h1F7, 0, 0);
    expect_rsp("R1 overlap cmd wins", 0, 0, 7, 0);
    issue(1'b0, 'h1F9, 0, 0);
    expect_rsp("R1 overlap tail ctrl", 1, 0, 3, 0);
    base_pctl = 16'h3F4;

    // R11 reset clears shadows (secondary shadow is 1 here)
    issue(1'b0, 'h170, 0, 0);
    expect_rsp("R11 pre-reset secondary", 0, 1, 0, 3);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R11 in reset", {rsp_valid, rsp_err}, 0);
    rst_n = 1'b1;
    issue(1'b0, 'h170, 0, 0);
    expect_rsp("R11 secondary shadow cleared", 0, 1, 0, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule